// File: doc/BRIEF.md
# In-Order Store Buffer with Ordering-Event Drain

This block sits between the execute stage of a core and its memory side. Each executed store arrives as an address, a data word and a 2-bit memory type. The block accepts the store into a small ring of entries and tells the core at once that the store is complete locally, before any write has been attempted. Stores then wait in the buffer until the core, or the buffer itself, asks for them to be written out.

A drain is started by a barrier request, a serialization event, an exception event, or by the buffer holding its last free entry. A drain covers every store accepted before the cycle of the event and writes them out one at a time, oldest first. The memory type of each entry decides where it goes: a cache write port, a direct memory write port, a write-combining port, or, for write-through, both the cache and the memory port. A barrier request is held by the requester and answered with a one-cycle acknowledge once every store accepted before the request has left the buffer. Stores that arrive later do not delay that acknowledge.

Each output port uses a valid/ready handshake, and the three ports share one address and data bus that always shows the oldest entry. DEPTH must be a power of two and at least 2.

Top module: `stbuf_drain`

## Requirements
- R1: After reset the buffer is empty: st_ready is 1, bar_ack is 0, and cache_valid, mem_valid and wc_valid are all 0.
- R2: st_done is 1 in exactly the cycles in which a store is accepted (st_valid and st_ready both 1).
- R3: st_ready is 0 exactly while DEPTH stores are held, and a store offered then is not taken.
- R4: Stores leave in the order they were accepted, and drain_addr and drain_data show the oldest held store while any port valid is 1; they stay stable while a presented port is not ready.
- R5: With no drain pending, held stores are not presented: all three port valids stay 0.
- R6: A serialization or exception pulse in cycle t drains every store accepted before cycle t. A store accepted in cycle t or later stays held unless a later event covers it.
- R7: When DEPTH stores are held, a drain of every held store starts without any event input.
- R8: A barrier request seen while no barrier is outstanding drains the stores accepted before that cycle. bar_ack is a one-cycle pulse raised in the first cycle in which all of them have left, whatever arrived after the request. The requester lowers bar_req after seeing bar_ack.
- R9: A store of type 00 (write-back) is sent on the cache port only and leaves on its cache handshake.
- R10: A store of type 01 (write-through) is offered on both the cache and the memory port. Each port is offered until it accepts and not again after that. The store leaves only when both ports have accepted it.
- R11: A store of type 10 (uncacheable) is sent on the memory port only and leaves on its memory handshake.
- R12: A store of type 11 (write-combining) is sent on the write-combining port only, with cache_valid and mem_valid both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Executed store offered |
| st_ready | output | 1 | A free entry is available |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_mtype | input | 2 | Memory type: 00 WB, 01 WT, 10 UC, 11 WC |
| st_done | output | 1 | Store completed locally this cycle |
| bar_req | input | 1 | Barrier request, held until acknowledged |
| bar_ack | output | 1 | Barrier complete, one-cycle pulse |
| ser_evt | input | 1 | Serialization event pulse |
| exc_evt | input | 1 | Exception event pulse |
| drain_addr | output | AW | Address of the oldest held store |
| drain_data | output | DW | Data of the oldest held store |
| cache_valid | output | 1 | Cache write offered |
| cache_ready | input | 1 | Cache accepts the write |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the write |
| wc_valid | output | 1 | Write-combining write offered |
| wc_ready | input | 1 | Write-combining port accepts the write |

## Verification
The hardest case to reach from the ports is a barrier whose acknowledge must wait for a write-through store whose two ports accept in different cycles, while new stores keep arriving behind the barrier and must not delay it. Directed phases stall the cache and memory readies one at a time on write-through entries, and they issue a barrier with stores arriving during the drain. A long phase driven by a pseudo-random sequence then mixes held barriers, event pulses, a buffer that keeps filling and independent ready stalls. A behavioural queue model is compared with every output on every cycle.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
    typedef enum logic [1:0] {
        MT_WB = 2'b00,
        MT_WT = 2'b01,
        MT_UC = 2'b10,
        MT_WC = 2'b11
    } mtype_e;
endpackage

// File: rtl/stbuf_ring.sv
module stbuf_ring #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int PW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic [1:0]    push_mt,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [1:0]    head_mt,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          full
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [AW-1:0] addr_d [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_d [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [1:0]    mt_d   [DEPTH];
    logic [1:0]    mt_q   [DEPTH];

    always_comb begin
        s_d    = s_q;
        addr_d = addr_q;
        data_d = data_q;
        mt_d   = mt_q;
        if (push) begin
            addr_d[s_q.wr[IW-1:0]] = push_addr;
            data_d[s_q.wr[IW-1:0]] = push_data;
            mt_d[s_q.wr[IW-1:0]]   = push_mt;
            s_d.wr = s_q.wr + PW'(1);
        end
        if (pop) begin
            s_d.rd = s_q.rd + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        data_q <= data_d;
        mt_q   <= mt_d;
    end

    assign head_addr = addr_q[s_q.rd[IW-1:0]];
    assign head_data = data_q[s_q.rd[IW-1:0]];
    assign head_mt   = mt_q[s_q.rd[IW-1:0]];
    assign wr_ptr    = s_q.wr;
    assign rd_ptr    = s_q.rd;
    assign full      = (s_q.wr[IW] != s_q.rd[IW]) && (s_q.wr[IW-1:0] == s_q.rd[IW-1:0]);
endmodule

// File: rtl/stbuf_order_ctl.sv
module stbuf_order_ctl #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    input  logic          full,
    input  logic          bar_req,
    input  logic          ser_evt,
    input  logic          exc_evt,
    output logic          drain_active,
    output logic          bar_ack
);
    typedef struct packed {
        logic [PW-1:0] mark;
        logic          bar_busy;
        logic [PW-1:0] bar_mark;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d          = c_q;
        drain_active = (rd_ptr != c_q.mark);
        bar_ack      = c_q.bar_busy && (rd_ptr == c_q.bar_mark);
        if (bar_ack) begin
            c_d.bar_busy = 1'b0;
        end
        if (bar_req && !c_q.bar_busy) begin
            c_d.bar_busy = 1'b1;
            c_d.bar_mark = wr_ptr;
            c_d.mark     = wr_ptr;
        end
        if (ser_evt || exc_evt || full) begin
            c_d.mark = wr_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/stbuf_router.sv
module stbuf_router
    import stbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [1:0] head_mt,
    input  logic       cache_ready,
    input  logic       mem_ready,
    input  logic       wc_ready,
    output logic       cache_valid,
    output logic       mem_valid,
    output logic       wc_valid,
    output logic       pop
);
    typedef struct packed {
        logic cache_done;
        logic mem_done;
    } wt_t;

    wt_t w_d, w_q;
    mtype_e mt;
    logic c_fire, m_fire, w_fire, c_all, m_all;

    always_comb begin
        w_d         = w_q;
        mt          = mtype_e'(head_mt);
        cache_valid = 1'b0;
        mem_valid   = 1'b0;
        wc_valid    = 1'b0;
        pop         = 1'b0;
        c_all       = 1'b0;
        m_all       = 1'b0;
        if (active) begin
            unique case (mt)
                MT_WB: cache_valid = 1'b1;
                MT_UC: mem_valid   = 1'b1;
                MT_WC: wc_valid    = 1'b1;
                MT_WT: begin
                    cache_valid = !w_q.cache_done;
                    mem_valid   = !w_q.mem_done;
                end
                default: ;
            endcase
        end
        c_fire = cache_valid && cache_ready;
        m_fire = mem_valid && mem_ready;
        w_fire = wc_valid && wc_ready;
        unique case (mt)
            MT_WB: pop = c_fire;
            MT_UC: pop = m_fire;
            MT_WC: pop = w_fire;
            MT_WT: begin
                c_all = w_q.cache_done || c_fire;
                m_all = w_q.mem_done || m_fire;
                pop   = active && c_all && m_all;
                if (active) begin
                    w_d.cache_done = pop ? 1'b0 : c_all;
                    w_d.mem_done   = pop ? 1'b0 : m_all;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end
endmodule

// File: rtl/stbuf_drain.sv
module stbuf_drain #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [1:0]    st_mtype,
    output logic          st_done,
    input  logic          bar_req,
    output logic          bar_ack,
    input  logic          ser_evt,
    input  logic          exc_evt,
    output logic [AW-1:0] drain_addr,
    output logic [DW-1:0] drain_data,
    output logic          cache_valid,
    input  logic          cache_ready,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          wc_valid,
    input  logic          wc_ready
);
    logic          push, pop, full, active;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [1:0]    head_mt;

    assign st_ready = !full;
    assign push     = st_valid && st_ready;
    assign st_done  = push;

    stbuf_ring #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .push_mt   (st_mtype),
        .pop       (pop),
        .head_addr (drain_addr),
        .head_data (drain_data),
        .head_mt   (head_mt),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .full      (full)
    );

    stbuf_order_ctl #(.PW(PW)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ptr       (wr_ptr),
        .rd_ptr       (rd_ptr),
        .full         (full),
        .bar_req      (bar_req),
        .ser_evt      (ser_evt),
        .exc_evt      (exc_evt),
        .drain_active (active),
        .bar_ack      (bar_ack)
    );

    stbuf_router u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .head_mt     (head_mt),
        .cache_ready (cache_ready),
        .mem_ready   (mem_ready),
        .wc_ready    (wc_ready),
        .cache_valid (cache_valid),
        .mem_valid   (mem_valid),
        .wc_valid    (wc_valid),
        .pop         (pop)
    );
endmodule

// File: rtl/stbuf_drain_chk.sv
module stbuf_drain_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          st_done,
    input logic          bar_ack,
    input logic [AW-1:0] drain_addr,
    input logic [DW-1:0] drain_data,
    input logic          cache_valid,
    input logic          cache_ready,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          wc_valid,
    input logic          wc_ready
);
    a_r2_done_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> (st_valid && st_ready));

    a_r4_cache_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && !cache_ready) |=> (cache_valid && $stable(drain_addr) && $stable(drain_data)));

    a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(drain_addr) && $stable(drain_data)));

    a_r12_wc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_valid && !wc_ready) |=> (wc_valid && $stable(drain_addr) && $stable(drain_data)));

    a_r12_wc_alone: assert property (@(posedge clk) disable iff (!rst_n)
        wc_valid |-> (!cache_valid && !mem_valid));

    a_r10_mem_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && cache_valid && !cache_ready) |=> !mem_valid);

    a_r10_cache_once: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_valid && cache_ready && mem_valid && !mem_ready) |=> !cache_valid);

    a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bar_ack |=> !bar_ack);
endmodule

bind stbuf_drain stbuf_drain_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .st_done     (st_done),
    .bar_ack     (bar_ack),
    .drain_addr  (drain_addr),
    .drain_data  (drain_data),
    .cache_valid (cache_valid),
    .cache_ready (cache_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .wc_valid    (wc_valid),
    .wc_ready    (wc_ready)
);

// File: tb/stbuf_drain_bench.sv
module stbuf_drain_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 0, bar_req = 0, ser_evt = 0, exc_evt = 0;
    logic cache_ready = 0, mem_ready = 0, wc_ready = 0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [1:0]    st_mtype = '0;
    logic st_ready, st_done, bar_ack, cache_valid, mem_valid, wc_valid;
    logic [AW-1:0] drain_addr;
    logic [DW-1:0] drain_data;

    always #5 clk = ~clk;

    stbuf_drain #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_stbuf_drain (.*);

    int errors = 0, checks = 0, cyc = 0;
    bit done_flag = 0;

    // behavioural model
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];
    logic [1:0]    q_mt[$];
    int n_in = 0, n_out = 0, mark = 0, bar_mark = 0;
    bit bar_busy = 0, wtc = 0, wtm = 0;
    bit e_rdy, e_done, e_cv, e_mv, e_wv, e_ack, e_act;
    bit last_ack = 0;
    logic [31:0] lfsr = 32'hACE1_2345;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic expect_outputs();
        logic [1:0] mt;
        e_rdy  = (n_in - n_out) < DEPTH;
        e_done = st_valid && e_rdy;
        e_act  = (n_out != mark);
        mt     = (q_mt.size() > 0) ? q_mt[0] : 2'b00;
        e_cv   = e_act && (mt == 2'b00 || (mt == 2'b01 && !wtc));
        e_mv   = e_act && (mt == 2'b10 || (mt == 2'b01 && !wtm));
        e_wv   = e_act && (mt == 2'b11);
        e_ack  = bar_busy && (n_out == bar_mark);
    endtask

    task automatic compare();
        string wt;
        expect_outputs();
        wt = (e_act && q_mt[0] == 2'b01) ? "R10" : "";
        chk("R3 st_ready", st_ready, e_rdy);
        chk("R2 st_done", st_done, e_done);
        chk(wt != "" ? "R10 cache_valid" : "R9 cache_valid", cache_valid, e_cv);
        chk(wt != "" ? "R10 mem_valid" : "R11 mem_valid", mem_valid, e_mv);
        chk("R12 wc_valid", wc_valid, e_wv);
        chk("R8 bar_ack", bar_ack, e_ack);
        if (e_act) begin
            chk("R4 drain_addr", drain_addr, q_addr[0]);
            chk("R4 drain_data", drain_data, q_data[0]);
        end
    endtask

    task automatic model_step();
        int wr_old;
        bit full_old, busy_old, cd, md, popit;
        wr_old   = n_in;
        full_old = (n_in - n_out) == DEPTH;
        busy_old = bar_busy;
        last_ack = e_ack;
        popit    = 0;
        if (e_act) begin
            case (q_mt[0])
                2'b00: popit = cache_ready;
                2'b10: popit = mem_ready;
                2'b11: popit = wc_ready;
                default: begin
                    cd = wtc || cache_ready;
                    md = wtm || mem_ready;
                    popit = cd && md;
                    wtc = popit ? 0 : cd;
                    wtm = popit ? 0 : md;
                end
            endcase
        end
        if (popit) begin
            void'(q_addr.pop_front());
            void'(q_data.pop_front());
            void'(q_mt.pop_front());
            n_out++;
        end
        if (st_valid && !full_old) begin
            q_addr.push_back(st_addr);
            q_data.push_back(st_data);
            q_mt.push_back(st_mtype);
            n_in++;
        end
        if (e_ack) bar_busy = 0;
        if (bar_req && !busy_old) begin
            bar_busy = 1;
            bar_mark = wr_old;
            mark     = wr_old;
        end
        if (ser_evt || exc_evt || full_old) mark = wr_old;
    endtask

    task automatic tick();
        #4;
        compare();
        model_step();
        @(negedge clk);
        cyc++;
    endtask

    task automatic put(logic [1:0] mt);
        st_valid = 1;
        st_mtype = mt;
        st_addr  = 32'h1000 + 32'(n_in) * 4;
        st_data  = 32'hD000_0000 + 32'(n_in);
        tick();
        st_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic all_ready(bit v);
        cache_ready = v; mem_ready = v; wc_ready = v;
    endtask

    function automatic logic [31:0] step_lfsr(logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #4;
        chk("R1 st_ready", st_ready, 1);
        chk("R1 bar_ack", bar_ack, 0);
        chk("R1 valids", {cache_valid, mem_valid, wc_valid}, 0);
        @(negedge clk);

        // R5: stores held with no drain pending
        all_ready(1);
        put(2'b00); put(2'b10); put(2'b11);
        idle(4);
        #1;
        chk("R5 held no valid", {cache_valid, mem_valid, wc_valid}, 0);

        // R6: serialization pulse with a store in the same cycle
        ser_evt = 1;
        put(2'b01);
        ser_evt = 0;
        idle(6);
        #1;
        chk("R6 later store held", {cache_valid, mem_valid, wc_valid}, 0);
        chk("R6 one left", q_mt.size(), 1);

        // R6: exception pulse with ready stalls, then WT split handshakes (R10)
        exc_evt = 1; tick(); exc_evt = 0;
        cache_ready = 1; mem_ready = 0; idle(3);
        cache_ready = 0; mem_ready = 1; idle(2);
        all_ready(1); idle(2);
        put(2'b01); put(2'b01);
        cache_ready = 0; mem_ready = 1;
        ser_evt = 1; tick(); ser_evt = 0;
        idle(3);
        cache_ready = 1; mem_ready = 0; idle(2);
        all_ready(1); idle(4);
        chk("R10 WT drained", q_mt.size(), 0);

        // R3/R7: fill with ports stalled
        all_ready(0);
        for (int i = 0; i < DEPTH + 2; i++) put(2'(i));
        #1;
        chk("R3 full ready low", st_ready, 0);
        chk("R7 drain started", cache_valid | mem_valid | wc_valid, 1);
        @(negedge clk);
        all_ready(1);
        idle(DEPTH + 6);

        // R8: barrier with stores arriving behind it
        all_ready(0);
        put(2'b00); put(2'b01); put(2'b10);
        bar_req = 1;
        put(2'b11);
        st_valid = 0;
        for (int i = 0; i < 40 && !last_ack; i++) begin
            cache_ready = i[0]; mem_ready = i[1]; wc_ready = 1;
            if (i < 4) put(2'b00); else tick();
        end
        bar_req = 0;
        chk("R8 later stores remain", q_mt.size() > 0, 1);
        all_ready(1);
        idle(3);
        // R8: barrier on an already drained front
        ser_evt = 1; tick(); ser_evt = 0; idle(8);
        bar_req = 1;
        for (int i = 0; i < 10 && !last_ack; i++) tick();
        bar_req = 0;
        chk("R8 empty barrier acked", last_ack, 1);
        idle(2);

        // mixed phase
        for (int i = 0; i < 4000; i++) begin
            lfsr = step_lfsr(lfsr);
            st_valid    = lfsr[0] | lfsr[1];
            st_mtype    = lfsr[3:2];
            st_addr     = {lfsr[31:4], 4'h0};
            st_data     = lfsr ^ 32'h5A5A_0F0F;
            cache_ready = lfsr[5] | lfsr[6];
            mem_ready   = lfsr[7] | lfsr[8];
            wc_ready    = lfsr[9];
            ser_evt     = (lfsr[15:11] == 5'd3);
            exc_evt     = (lfsr[20:16] == 5'd7);
            if (last_ack) bar_req = 0;
            else if (!bar_req && lfsr[26:21] == 6'd9) bar_req = 1;
            tick();
        end
        st_valid = 0; ser_evt = 0; exc_evt = 0;
        if (last_ack) bar_req = 0;
        all_ready(1);
        for (int i = 0; i < 60 && bar_req; i++) begin
            tick();
            if (last_ack) bar_req = 0;
        end
        idle(4);
        finish_run();
    end
endmodule